// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter driven from a divided copy of the system clock and governed by one 8-bit control/status byte. Software picks one of two uses. As an interval timer, every wrap of the counter from 0xFF to 0x00 raises an interrupt request. As a watchdog, software must reload the counter before it wraps. If it does not, the wrap raises a reset request or a non-maskable interrupt request, chosen by a routing bit.

Software reaches the block through a small register bus. Address 0 is the control/status byte and address 1 is the count. Every write carries a 16-bit word whose upper byte must hold the key 0xA5 and whose lower byte carries the data. A write without the key is dropped. The overflow flag has a guarded clear: it can only be cleared by a keyed write of 0 that follows a read which saw the flag at 1. A standby input wipes the mode, enable, routing and flag state but keeps the chosen clock rate.

Top module: `wdog_itimer`

## Requirements
- R1: The control byte at address 0 reads as {flag[7], mode[6] (1 = watchdog, 0 = interval), enable[5], constant 1 at bit 4, route[3] (1 = reset, 0 = NMI), rate[2:0]}. After reset it reads 0x10 and the count at address 1 reads 0x00.
- R2: A write to either address takes effect only when bus_wdata[15:8] equals 0xA5. Any other upper byte leaves both the control byte and the count unchanged.
- R3: While enable is 0, the count is held at 0x00. Clearing enable brings the count back to 0x00 on the next clock.
- R4: While enable is 1, the count steps by one every 2^(rate+1) clocks. The divider starts from zero whenever enable is 0, so the first step comes on the 2^(rate+1)-th clock after enable turns on.
- R5: When the count steps from 0xFF to 0x00, the flag is set on that same clock edge.
- R6: In interval mode, a wrap drives irq_interval high for exactly one clock, in the cycle that follows the wrap edge.
- R7: In watchdog mode, a wrap pulses req_reset for one clock when route is 1 and req_nmi for one clock when route is 0. At most one request output is high at a time.
- R8: The flag clears only on a keyed control write with bit 7 = 0 that is the first control write after a read of address 0 that saw the flag at 1. Writing 1 to bit 7 has no effect, and so does writing 0 without that earlier read.
- R9: If a clearing write and a wrap land on the same clock, the flag stays set.
- R10: While standby is high, flag, mode, enable and route are cleared, rate keeps its value, and writes are ignored.
- R11: A keyed write to address 1 loads the count from bus_wdata[7:0]. A load on the clock where a wrap would happen replaces the wrap, so the flag is not set and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Standby level; clears the run state while high |
| bus_addr | input | 1 | 0 = control/status byte, 1 = count |
| bus_wdata | input | 16 | Key in [15:8], data in [7:0] |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for the addressed byte |
| irq_interval | output | 1 | Interval interrupt request pulse |
| req_reset | output | 1 | Watchdog reset request pulse |
| req_nmi | output | 1 | Watchdog NMI request pulse |

## Verification
A divider that runs off by one would move every wrap by whole rate periods, so it shows up in the count read back within the first 2^(rate+1) clocks after enabling. A wrong arm bit for the flag clear shows at address 0 on the very next read, because the flag is either still set or cleared too early. The request registers decide which output pulses one clock after a wrap, so a bad mode or route decode is visible at the outputs within one clock of the count passing 0xFF. Standby damage to the rate field shows up only when counting resumes, as a changed step period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned RATE_W = 3;
  localparam logic [7:0]  KEY    = 8'hA5;

  typedef struct packed {
    logic              flag;
    logic              mode;
    logic              en;
    logic              resv;
    logic              route;
    logic [RATE_W-1:0] rate;
  } ctrl_view_t;

  function automatic logic [7:0] pack_ctrl(input logic flag, input logic mode,
                                           input logic en, input logic route,
                                           input logic [RATE_W-1:0] rate);
    ctrl_view_t v;
    v.flag  = flag;
    v.mode  = mode;
    v.en    = en;
    v.resv  = 1'b1;
    v.route = route;
    v.rate  = rate;
    return v;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [DIV_W-1:0] div_q;

  function automatic logic [DIV_W-1:0] rate_mask(input logic [RATE_W-1:0] r);
    return (DIV_W'(2) << r) - DIV_W'(1);
  endfunction

  assign tick = run && ((div_q & rate_mask(rate)) == rate_mask(rate));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (!run) div_q <= '0;
    else          div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  assign wrap = run && tick && !load && (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (!run)   count <= '0;
    else if (load)   count <= load_val;
    else if (tick)   count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int unsigned RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd,
  input  logic [7:0]        wdata,
  input  logic              wrap,
  output logic              flag,
  output logic              mode,
  output logic              en,
  output logic              route,
  output logic [RATE_W-1:0] rate
);
  logic arm_q;
  logic rd_hit;
  logic clear_req;

  assign rd_hit    = ctrl_rd && flag;
  assign clear_req = ctrl_wr && !wdata[7] && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      mode  <= 1'b0;
      en    <= 1'b0;
      route <= 1'b0;
      rate  <= '0;
      arm_q <= 1'b0;
    end else if (standby) begin
      flag  <= 1'b0;
      mode  <= 1'b0;
      en    <= 1'b0;
      route <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode  <= wdata[6];
        en    <= wdata[5];
        route <= wdata[3];
        rate  <= wdata[RATE_W-1:0];
      end
      if (wrap)           flag <= 1'b1;
      else if (clear_req) flag <= 1'b0;
      if (rd_hit)         arm_q <= 1'b1;
      else if (ctrl_wr)   arm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standby,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_rd,
  input  logic        bus_wr,
  output logic [7:0]  bus_rdata,
  output logic        irq_interval,
  output logic        req_reset,
  output logic        req_nmi
);
  logic              wr_ok;
  logic              ctrl_wr;
  logic              ctrl_rd;
  logic              cnt_ld;
  logic              tick;
  logic              wrap_evt;
  logic              flag_q, mode_q, en_q, route_q;
  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  count_q;

  assign wr_ok   = bus_wr && (bus_wdata[15:8] == KEY) && !standby;
  assign ctrl_wr = wr_ok && !bus_addr;
  assign cnt_ld  = wr_ok && bus_addr;
  assign ctrl_rd = bus_rd && !bus_addr;

  wdog_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .wdata(bus_wdata[7:0]),
    .wrap(wrap_evt), .flag(flag_q), .mode(mode_q), .en(en_q),
    .route(route_q), .rate(rate_q)
  );

  wdog_prescaler #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en_q), .rate(rate_q), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(en_q), .tick(tick),
    .load(cnt_ld), .load_val(bus_wdata[CNT_W-1:0]),
    .count(count_q), .wrap(wrap_evt)
  );

  assign bus_rdata = bus_addr ? count_q
                              : pack_ctrl(flag_q, mode_q, en_q, route_q, rate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_interval <= 1'b0;
      req_reset    <= 1'b0;
      req_nmi      <= 1'b0;
    end else begin
      irq_interval <= wrap_evt && !mode_q;
      req_reset    <= wrap_evt && mode_q && route_q;
      req_nmi      <= wrap_evt && mode_q && !route_q;
    end
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned RATE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              bus_wr,
  input logic [15:0]       bus_wdata,
  input logic              irq_interval,
  input logic              req_reset,
  input logic              req_nmi,
  input logic              wrap,
  input logic              flag,
  input logic              mode,
  input logic              en,
  input logic              route,
  input logic [RATE_W-1:0] rate,
  input logic [CNT_W-1:0]  count
);
  p_disabled_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> count == '0);

  p_no_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[15:8] != 8'hA5 && !standby)
      |=> ($stable(mode) && $stable(en) && $stable(route) && $stable(rate)));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !standby) |=> flag);

  p_interval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !mode) |=> (irq_interval && !req_reset && !req_nmi));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_interval |=> !irq_interval);

  p_route_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode && route) |=> req_reset);

  p_route_nmi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode && !route) |=> req_nmi);

  p_one_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_interval, req_reset, req_nmi}));

  p_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!flag && !en && !mode && !route && rate == $past(rate)));
endmodule

bind wdog_itimer wdog_checker #(.CNT_W(wdog_pkg::CNT_W), .RATE_W(wdog_pkg::RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq_interval(irq_interval), .req_reset(req_reset),
  .req_nmi(req_nmi), .wrap(wrap_evt), .flag(flag_q), .mode(mode_q),
  .en(en_q), .route(route_q), .rate(rate_q), .count(count_q)
);

// File: tb/tb_wdog_itimer.sv
module tb_wdog_itimer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic        irq_interval, req_reset, req_nmi;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference state kept by the bench
  logic [7:0] m_cnt, m_div;
  logic       m_flag, m_mode, m_en, m_route, m_arm;
  logic [2:0] m_rate;
  logic       m_irq, m_rst, m_nmi;
  int         irq_seen, rst_seen, nmi_seen;

  always #2 clk = ~clk;

  wdog_itimer dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .irq_interval(irq_interval),
    .req_reset(req_reset), .req_nmi(req_nmi)
  );

  function automatic logic [7:0] period_mask(input logic [2:0] r);
    logic [7:0] m = 8'h01;
    for (int i = 0; i < 3; i++) if (r[i]) m = m * ((8'd1 << (1 << i)));
    return (m << 1) - 8'd1;
  endfunction

  function automatic logic [7:0] ctrl_byte();
    return {m_flag, m_mode, m_en, 1'b1, m_route, m_rate};
  endfunction

  function automatic bit tick_next();
    return m_en && ((m_div & period_mask(m_rate)) == period_mask(m_rate));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_div = 0; m_flag = 0; m_mode = 0; m_en = 0; m_route = 0;
    m_arm = 0; m_rate = 0; m_irq = 0; m_rst = 0; m_nmi = 0;
  endtask

  task automatic model_step(input logic stb, input logic a, input logic [15:0] wd,
                            input logic rd, input logic wr);
    bit keyed, ld, tk, ovf, clr;
    logic [7:0] n_cnt;
    keyed = wr && (wd[15:8] == 8'hA5) && !stb;
    ld    = keyed && a;
    tk    = tick_next();
    ovf   = tk && (m_cnt == 8'hFF) && !ld;
    clr   = keyed && !a && !wd[7] && m_arm;
    n_cnt = !m_en ? 8'h00 : ld ? wd[7:0] : tk ? m_cnt + 8'd1 : m_cnt;
    m_irq = ovf && !m_mode;
    m_rst = ovf && m_mode && m_route;
    m_nmi = ovf && m_mode && !m_route;
    m_div = m_en ? m_div + 8'd1 : 8'd0;
    m_cnt = n_cnt;
    if (stb) begin
      m_flag = 0; m_mode = 0; m_en = 0; m_route = 0; m_arm = 0;
    end else begin
      if (ovf) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      if (rd && !a && m_flag_before_read(ovf, clr)) m_arm = 1'b1;
      else if (keyed && !a) m_arm = 1'b0;
      if (keyed && !a) begin
        m_mode = wd[6]; m_en = wd[5]; m_route = wd[3]; m_rate = wd[2:0];
      end
    end
  endtask

  // flag value seen by a read is the one held before the edge
  logic pre_flag;
  function automatic bit m_flag_before_read(input bit o, input bit c);
    return pre_flag && (o || c || 1'b1);
  endfunction

  task automatic step(input logic stb, input logic a, input logic [15:0] wd,
                      input logic rd, input logic wr);
    @(negedge clk);
    standby = stb; bus_addr = a; bus_wdata = wd; bus_rd = rd; bus_wr = wr;
    pre_flag = m_flag;
    model_step(stb, a, wd, rd, wr);
    @(posedge clk);
    #1;
    if (irq_interval) irq_seen++;
    if (req_reset) rst_seen++;
    if (req_nmi) nmi_seen++;
    chk(bus_rdata == (a ? m_cnt : ctrl_byte()), a ? "R4 count" : "R1 ctrl",
        bus_rdata, a ? m_cnt : ctrl_byte());
    chk(irq_interval == m_irq, "R6 irq_interval", irq_interval, m_irq);
    chk(req_reset == m_rst, "R7 req_reset", req_reset, m_rst);
    chk(req_nmi == m_nmi, "R7 req_nmi", req_nmi, m_nmi);
  endtask

  task automatic idle(input int n, input logic a);
    for (int i = 0; i < n; i++) step(1'b0, a, 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    step(1'b0, 1'b0, {8'hA5, v}, 1'b0, 1'b1);
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    step(1'b0, 1'b1, {8'hA5, v}, 1'b0, 1'b1);
  endtask

  task automatic rd_ctrl();
    step(1'b0, 1'b0, 16'h0000, 1'b1, 1'b0);
  endtask

  task automatic wait_wrap_edge();
    for (int i = 0; i < 2000 && !(tick_next() && m_cnt == 8'hFF); i++) idle(1, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    pre_flag = 0;
    irq_seen = 0; rst_seen = 0; nmi_seen = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(bus_rdata == 8'h10, "R1 reset ctrl", bus_rdata, 8'h10);
    @(negedge clk) rst_n = 1'b1;
    idle(1, 1'b1);
    chk(bus_rdata == 8'h00, "R3 reset count", bus_rdata, 8'h00);

    // R2: keyless writes dropped
    step(1'b0, 1'b0, 16'h5A3F, 1'b0, 1'b1);
    chk(bus_rdata == 8'h10, "R2 keyless ctrl", bus_rdata, 8'h10);
    wr_ctrl(8'h20);
    step(1'b0, 1'b1, 16'h0077, 1'b0, 1'b1);
    chk(bus_rdata == 8'h00 || bus_rdata == 8'h01, "R2 keyless count", bus_rdata, 8'h00);

    // R4: first step after two clocks at rate 0
    wr_ctrl(8'h00);
    wr_ctrl(8'h20);
    idle(2, 1'b1);
    chk(bus_rdata == 8'h01, "R4 rate0 first step", bus_rdata, 8'h01);

    // R5/R6: interval wrap
    irq_seen = 0;
    wr_cnt(8'hFE);
    idle(8, 1'b1);
    chk(irq_seen == 1, "R6 one irq pulse", irq_seen, 1);
    idle(1, 1'b0);
    chk(bus_rdata[7] == 1'b1, "R5 flag set", bus_rdata[7], 1);

    // R8: guarded clear
    wr_ctrl(8'h20);
    chk(bus_rdata[7] == 1'b1, "R8 clear without read", bus_rdata[7], 1);
    rd_ctrl();
    wr_ctrl(8'hA0);
    chk(bus_rdata[7] == 1'b1, "R8 write one", bus_rdata[7], 1);
    rd_ctrl();
    wr_ctrl(8'h20);
    chk(bus_rdata[7] == 1'b0, "R8 read then clear", bus_rdata[7], 0);

    // R9: clear collides with wrap
    wr_cnt(8'hFD);
    wait_wrap_edge();
    idle(1, 1'b1);
    rd_ctrl();
    wr_cnt(8'hFE);
    wait_wrap_edge();
    wr_ctrl(8'h20);
    chk(bus_rdata[7] == 1'b1, "R9 wrap beats clear", bus_rdata[7], 1);

    // R7: watchdog routing
    rst_seen = 0; nmi_seen = 0; irq_seen = 0;
    wr_ctrl(8'h68);
    wr_cnt(8'hFE);
    idle(8, 1'b1);
    chk(rst_seen == 1 && nmi_seen == 0 && irq_seen == 0, "R7 reset route", rst_seen, 1);
    rst_seen = 0;
    wr_ctrl(8'h60);
    wr_cnt(8'hFE);
    idle(8, 1'b1);
    chk(nmi_seen == 1 && rst_seen == 0, "R7 nmi route", nmi_seen, 1);

    // R3 and R4 at rate 3
    wr_ctrl(8'h03);
    idle(1, 1'b1);
    chk(bus_rdata == 8'h00, "R3 disable zeroes", bus_rdata, 8'h00);
    idle(5, 1'b1);
    chk(bus_rdata == 8'h00, "R3 held at zero", bus_rdata, 8'h00);
    wr_ctrl(8'h23);
    idle(15, 1'b1);
    chk(bus_rdata == 8'h00, "R4 rate3 before step", bus_rdata, 8'h00);
    idle(1, 1'b1);
    chk(bus_rdata == 8'h01, "R4 rate3 on 16th clock", bus_rdata, 8'h01);

    // R11: load replaces wrap
    wr_ctrl(8'h20);
    irq_seen = 0;
    wr_cnt(8'hFD);
    wait_wrap_edge();
    wr_cnt(8'h10);
    idle(3, 1'b1);
    chk(irq_seen == 0, "R11 no wrap on load", irq_seen, 0);
    chk(bus_rdata == 8'h10 || bus_rdata == 8'h11, "R11 loaded value", bus_rdata, 8'h10);

    // R10: standby
    wr_ctrl(8'h6D);
    step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
    chk(bus_rdata == 8'h15, "R10 standby clears", bus_rdata, 8'h15);
    step(1'b1, 1'b0, 16'hA527, 1'b0, 1'b1);
    chk(bus_rdata == 8'h15, "R10 write in standby", bus_rdata, 8'h15);
    idle(1, 1'b1);
    chk(bus_rdata == 8'h00, "R10 count stopped", bus_rdata, 8'h00);

    // constrained random run
    for (int n = 0; n < 20000; n++) begin
      logic stb, a, rd, wr;
      logic [15:0] wd;
      stb = ($urandom % 300) == 0;
      a   = $urandom % 2;
      rd  = ($urandom % 3) == 0;
      wr  = !rd && (($urandom % 12) == 0);
      wd[15:8] = (($urandom % 8) != 0) ? 8'hA5 : 8'($urandom);
      if (a) wd[7:0] = (($urandom % 2) != 0) ? 8'hFC + 8'($urandom % 4) : 8'($urandom);
      else begin
        wd[7:0] = 8'($urandom);
        wd[5]   = ($urandom % 5) != 0;
        wd[2:0] = 3'($urandom % 3);
      end
      step(stb, a, wd, rd, wr);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule